// File: doc/BRIEF.md
# Pad Drive-Strength Control Latches with Scan Rewrite

This block holds a small bank of pad drive-strength bits. They can be set in two ways. While the system reset input is held low and system logic owns the pins, the bank follows a 3-bit strap bus, so the value present when reset is released is the value that stays. After reset, a dedicated scan instruction can rewrite the bank through the test data path. The path has a capture step, a shift step and an update step.

The TAP controller, the instruction decoder and the pad cells sit outside this block. It receives decoded capture, shift and update strobes. It also receives a one-cycle `tck_pulse` that marks a rising test-clock edge, sampled in the block's clock domain. A select flag says the drive-control instruction is the current one.

A counter measures a settling window of `WIN` clocks after reset is released. Scan writes to the bank are refused until that window has finished, and the end of the window is shown on `ready`. When the drive-control instruction is not selected, test-port activity leaves the block alone.

Top module: `drv_ctl_latch`

## Requirements
- R1: While `rst_n` is low and `sys_owns` is high, `drive` takes the value of `strap` one clock later. The value loaded on the last low cycle is held after `rst_n` rises.
- R2: Time is counted in rising `clk` edges sampled with `rst_n` high. `ready` is 0 after fewer than `WIN` such edges and 1 from the `WIN`-th edge onward. Once set, it stays 1 until `rst_n` goes low, which clears it on the next edge.
- R3: An update strobe (`tck_pulse`, `sel` and `dr_update` all high) is ignored while `ready` is 0, and `drive` keeps its value.
- R4: An update strobe taken while `ready` is 1 copies the scan stage into `drive` on that edge.
- R5: `drive` changes only by the strap load of R1 or the update of R4. Capture and shift strobes never change it.
- R6: With `tck_pulse`, `sel` and `dr_shift` high, the 3-bit scan stage moves one place toward bit 0 and takes `tdi` into bit 2. `tdo` always shows stage bit 0, so data leaves LSB first. Without `tck_pulse`, no TAP strobe has any effect.
- R7: With `tck_pulse`, `sel` and `dr_capture` high, the scan stage loads the current `drive`. The first bit out on `tdo` is then `drive[0]`. Capture takes priority over shift when both are high.
- R8: While `sel` is 0, capture, shift and update strobes leave both the scan stage (seen on `tdo`) and `drive` unchanged.
- R9: While `sys_owns` is 0, holding `rst_n` low leaves `drive` unchanged, but the scan stage is still cleared to 0 and `ready` is still cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; the settling window is counted in these cycles |
| rst_n | input | 1 | Active-low system reset, synchronous |
| sys_owns | input | 1 | 1 when system logic owns pad directions and levels |
| strap | input | 3 | Strap value loaded into the bank during reset |
| tck_pulse | input | 1 | One-cycle marker of a rising test-clock edge |
| tdi | input | 1 | Serial test data in |
| dr_capture | input | 1 | Decoded capture-DR state |
| dr_shift | input | 1 | Decoded shift-DR state |
| dr_update | input | 1 | Decoded update-DR state |
| sel | input | 1 | Drive-control instruction selected |
| drive | output | 3 | Drive-strength bits to the pads |
| tdo | output | 1 | Serial test data out (scan stage bit 0) |
| ready | output | 1 | Settling window after reset has finished |

## Verification
Two functions can meet on the same edge: an update strobe, and the counter edge on which the settling window closes and `ready` rises. The directed case aims an update at exactly that edge and expects it to be refused. A second update one clock later must be accepted. A second meeting point is a reset assertion that lands on the same cycle as an update strobe. The random phase creates both kinds of overlap many times over, and a cycle-level model in the bench decides every outcome.

// File: rtl/drv_pkg.sv
package drv_pkg;
  localparam int DRV_W = 3;
  typedef logic [DRV_W-1:0] drv_t;

  // next scan stage value for one shift step: tdi enters the top, bit 0 leaves
  function automatic drv_t shift_step(input drv_t cur, input logic din);
    return {din, cur[DRV_W-1:1]};
  endfunction

  // true when the counter value marks the last cycle of the window
  function automatic logic window_last(input int unsigned cnt, input int unsigned win);
    return cnt == (win - 1);
  endfunction
endpackage

// File: rtl/drv_window.sv
module drv_window #(
  parameter int WIN = 128
) (
  input  logic clk,
  input  logic rst_n,
  output logic rdy
);
  localparam int CW = (WIN > 2) ? $clog2(WIN) : 1;

  logic [CW-1:0] cnt;
  logic          last_evt;

  assign last_evt = rst_n && !rdy && drv_pkg::window_last(32'(cnt), WIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      rdy <= 1'b0;
    end else if (!rdy) begin
      if (last_evt) rdy <= 1'b1;
      else          cnt <= cnt + 1'b1;
    end
  end

  // R2: ready is sticky until reset
  a_r2_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> rdy);
  // R2: ready rises only out of the last counter value
  a_r2_rise_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $past(cnt) == CW'(WIN - 1));
  // R2: no early ready
  a_r2_not_early: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy && !last_evt) |=> !rdy);
endmodule

// File: rtl/drv_scan.sv
module drv_scan
  import drv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic sh_en,
  input  logic tdi,
  input  drv_t par_in,
  output drv_t sh,
  output logic tdo
);
  always_ff @(posedge clk) begin
    if (!rst_n)      sh <= '0;
    else if (cap_en) sh <= par_in;
    else if (sh_en)  sh <= shift_step(sh, tdi);
  end

  assign tdo = sh[0];

  // R6: serial input lands at the top bit
  a_r6_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_en && !cap_en) |=> sh[DRV_W-1] == $past(tdi));
  // R7: capture takes the parallel value
  a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> sh == $past(par_in));
  // R8: no strobe means no movement
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !sh_en) |=> $stable(sh));
endmodule

// File: rtl/drv_bank.sv
module drv_bank
  import drv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sys_owns,
  input  drv_t strap,
  input  logic upd_fire,
  input  drv_t upd_val,
  output drv_t q
);
  logic strap_ld;
  assign strap_ld = !rst_n && sys_owns;

  always_ff @(posedge clk) begin
    if (strap_ld)      q <= strap;
    else if (upd_fire) q <= upd_val;
  end

  // R1: bank follows the strap while reset is low and the system owns the pins
  a_r1_strap_follow: assert property (@(posedge clk)
    strap_ld |=> q == $past(strap));
  // R4: an accepted update copies the scan value
  a_r4_update_load: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && rst_n) |=> q == $past(upd_val));
  // R5: nothing else moves the bank
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !upd_fire) |=> $stable(q));
endmodule

// File: rtl/drv_ctl_latch.sv
module drv_ctl_latch #(
  parameter int WIN = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_owns,
  input  logic [2:0] strap,
  input  logic       tck_pulse,
  input  logic       tdi,
  input  logic       dr_capture,
  input  logic       dr_shift,
  input  logic       dr_update,
  input  logic       sel,
  output logic [2:0] drive,
  output logic       tdo,
  output logic       ready
);
  import drv_pkg::*;

  logic tap_live;
  logic cap_en;
  logic sh_en;
  logic upd_req;
  logic upd_fire;
  drv_t sh_q;
  drv_t bank_q;

  assign tap_live = tck_pulse && sel;
  assign cap_en   = tap_live && dr_capture;
  assign sh_en    = tap_live && dr_shift && !dr_capture;
  assign upd_req  = tap_live && dr_update;
  assign upd_fire = upd_req && ready && rst_n;

  drv_window #(.WIN(WIN)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .rdy   (ready)
  );

  drv_scan u_scan (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (cap_en),
    .sh_en  (sh_en),
    .tdi    (tdi),
    .par_in (bank_q),
    .sh     (sh_q),
    .tdo    (tdo)
  );

  drv_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .sys_owns (sys_owns),
    .strap    (strap),
    .upd_fire (upd_fire),
    .upd_val  (sh_q),
    .q        (bank_q)
  );

  assign drive = bank_q;

  // R3: the bank is frozen while the window runs
  a_r3_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready) |=> $stable(drive));
  // R8: deselected strobes leave the scan stage alone
  a_r8_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel) |=> $stable(sh_q));
  // R9: reset with test-owned pins keeps the bank
  a_r9_test_owned: assert property (@(posedge clk)
    (!rst_n && !sys_owns) |=> $stable(drive));
endmodule

// File: tb/sim_drv_ctl_latch.sv
module sim_drv_ctl_latch;
  localparam int WIN = 128;

  logic clk = 1'b0;
  logic rst_n, sys_owns, tck_pulse, tdi, dr_capture, dr_shift, dr_update, sel;
  logic [2:0] strap;
  logic [2:0] drive;
  logic tdo, ready;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [2:0] m_drv, m_sh;
  logic m_rdy;
  int   m_cnt;

  always #4 clk = ~clk;

  drv_ctl_latch #(.WIN(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .sys_owns(sys_owns), .strap(strap),
    .tck_pulse(tck_pulse), .tdi(tdi), .dr_capture(dr_capture),
    .dr_shift(dr_shift), .dr_update(dr_update), .sel(sel),
    .drive(drive), .tdo(tdo), .ready(ready)
  );

  function automatic logic [2:0] f_shift(input logic [2:0] s, input logic d);
    return {d, s[2], s[1]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: model update at the edge, compare at the following falling edge
  task automatic step(input string tag);
    logic [2:0] nd, ns;
    logic tl;
    @(posedge clk);
    nd = m_drv; ns = m_sh;
    tl = tck_pulse && sel;
    if (!rst_n) begin
      if (sys_owns) nd = strap;
      ns = 3'b000;
    end else begin
      if (tl && dr_capture)    ns = m_drv;
      else if (tl && dr_shift) ns = f_shift(m_sh, tdi);
      if (tl && dr_update && m_rdy) nd = m_sh;
    end
    if (!rst_n) begin
      m_cnt = 0; m_rdy = 1'b0;
    end else if (!m_rdy) begin
      if (m_cnt == WIN - 1) m_rdy = 1'b1;
      else m_cnt++;
    end
    m_drv = nd; m_sh = ns;
    @(negedge clk);
    chk({tag, " R5 drive"}, 32'(drive), 32'(m_drv));
    chk({tag, " R2 ready"}, 32'(ready), 32'(m_rdy));
    chk({tag, " R6 tdo"},   32'(tdo),   32'(m_sh[0]));
  endtask

  task automatic idle();
    tck_pulse = 0; dr_capture = 0; dr_shift = 0; dr_update = 0; tdi = 0;
  endtask

  task automatic tap(input logic c, input logic s, input logic u, input logic d, input string tag);
    tck_pulse = 1; dr_capture = c; dr_shift = s; dr_update = u; tdi = d;
    step(tag);
    idle();
  endtask

  task automatic scan_write(input logic [2:0] v, input string tag);
    tap(1, 0, 0, 0, tag);
    for (int i = 0; i < 3; i++) tap(0, 1, 0, v[i], tag);
    tap(0, 0, 1, 0, tag);
  endtask

  task automatic reset_cycle(input int n, input string tag);
    rst_n = 0;
    for (int i = 0; i < n; i++) step(tag);
    rst_n = 1;
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1093));
    rst_n = 0; sys_owns = 1; strap = 3'b110; sel = 0;
    m_drv = 3'b110; m_sh = 0; m_rdy = 0; m_cnt = 0;
    idle();
    @(negedge clk);
    // R1: follow strap during reset, hold after release
    reset_cycle(3, "R1 reset");
    chk("R1 strap held", 32'(drive), 32'(3'b110));
    strap = 3'b001;
    // R2: exact window edge
    for (int i = 0; i < WIN - 1; i++) step("R2 window");
    chk("R2 not yet", 32'(ready), 32'd0);
    step("R2 window");
    chk("R2 risen", 32'(ready), 32'd1);

    // R3: update aimed at the edge where ready rises is refused
    sel = 1;
    reset_cycle(2, "R3 reset");
    tap(1, 0, 0, 0, "R3");
    for (int i = 0; i < 3; i++) tap(0, 1, 0, 1'b1, "R3");
    while (m_cnt < WIN - 1) step("R3 wait");
    tap(0, 0, 1, 0, "R3 edge");
    chk("R3 refused", 32'(drive), 32'(3'b001));
    tap(0, 0, 1, 0, "R4 after");
    chk("R4 accepted", 32'(drive), 32'(3'b111));

    // R4 / R7: scan write then read back LSB first
    scan_write(3'b101, "R4 write");
    chk("R4 value", 32'(drive), 32'(3'b101));
    tap(1, 0, 0, 0, "R7 capture");
    chk("R7 first bit", 32'(tdo), 32'd1);
    tap(0, 1, 0, 0, "R6 shift");
    chk("R6 second bit", 32'(tdo), 32'd0);
    // R7: capture beats shift
    tap(1, 1, 0, 1, "R7 priority");
    chk("R7 priority", 32'(tdo), 32'd1);

    // R8: deselected strobes
    sel = 0;
    tap(1, 0, 0, 0, "R8"); tap(0, 1, 0, 0, "R8"); tap(0, 0, 1, 0, "R8");
    chk("R8 drive kept", 32'(drive), 32'(3'b101));
    sel = 1;
    // R6: strobes without tck_pulse
    dr_shift = 1; dr_update = 1; tdi = 0; step("R6 no pulse"); idle();
    chk("R6 no pulse", 32'(drive), 32'(3'b101));

    // R9: reset with test-owned pins keeps scanned bits
    sys_owns = 0; strap = 3'b010;
    reset_cycle(4, "R9");
    chk("R9 kept", 32'(drive), 32'(3'b101));
    chk("R9 ready cleared", 32'(ready), 32'd0);
    sys_owns = 1;
    reset_cycle(1, "R1 reload");
    chk("R1 reload", 32'(drive), 32'(3'b010));

    // random mix
    for (int n = 0; n < 6000; n++) begin
      logic [31:0] r;
      r = $urandom;
      rst_n = (r[5:0] != 0) || (n < 10);
      if (r[13:8] == 0) sys_owns = ~sys_owns;
      strap = r[16:14];
      sel = r[19:17] != 0;
      tck_pulse = r[20];
      case (r[22:21])
        2'd0: begin dr_capture = 1; dr_shift = 0; dr_update = 0; end
        2'd1: begin dr_capture = 0; dr_shift = 1; dr_update = 0; end
        2'd2: begin dr_capture = 0; dr_shift = 0; dr_update = 1; end
        default: begin dr_capture = r[23]; dr_shift = r[24]; dr_update = r[25]; end
      endcase
      tdi = r[26];
      step("rand");
    end
    idle();
    rst_n = 1;
    step("end");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule